// File: doc/BRIEF.md
# Four-Channel Counter/Timer with Vectored Interrupts

This peripheral holds four independent counter/timer channels behind an 8-bit write-only register port. Each channel has an 8-bit down-counter, a reload register and a trigger input. It produces a one-cycle pulse when its count expires. In timer mode a channel counts system clocks through its own prescaler, which divides by 16 or by 256. In counter mode it counts edges of its trigger input, on the polarity that software selects. When the count expires, the channel reloads its constant and can raise an interrupt.

Software writes a single vector base. When an interrupt is acknowledged, the block returns a vector that is unique to the winning channel. An enable input and an enable output chain the block into a priority daisy chain with other devices. A return-from-interrupt strobe ends service of the current channel.

The CPU selects a channel with `wr_sel` and writes one byte. Bit 0 set marks a control word. Control-word fields: bit 7 interrupt enable, bit 6 counter mode (0 selects timer), bit 5 prescale by 256 (0 selects 16), bit 4 rising edge (0 selects falling), bit 3 timer waits for a trigger edge, bit 2 a time constant follows, bit 1 halt. The byte written after a control word with bit 2 set is the time constant. A byte with bit 0 clear, sent to channel 0 when no constant is due, loads the vector base from bits 7:3.

Top module: `quad_ctr_timer`

## Requirements
- R1: After reset, `zc_out`, `int_req` and `vec_valid` are low and `ien_out` equals `ien_in`.
- R2: In timer mode with prescale 16 and constant N, the first `zc_out` pulse is visible 16·N cycles after the cycle in which the constant is written. Pulses then repeat every 16·N cycles through automatic reload. Each pulse lasts one cycle.
- R3: Control bit 5 set selects prescale 256, so the period becomes 256·N cycles.
- R4: A time constant of 0 counts 256 steps.
- R5: In counter mode (bit 6) the count steps on the trigger edge chosen by bit 4 (1 rising, 0 falling), and edges of the other polarity are ignored. The pulse appears in the cycle after the expiring edge is sampled.
- R6: A timer with bit 3 set does not count until a trigger edge. Its first pulse follows 16·N cycles after that edge.
- R7: A control word with bit 1 set stops the channel. It stays silent until a new time constant is written.
- R8: An expiry with bit 7 set makes the channel pending, and `int_req` rises one cycle after the pulse while `ien_in` is high. An expiry with bit 7 clear never raises `int_req`.
- R9: One cycle after `inta` is sampled with `int_req` high, `vec_valid` pulses with `vec_out` = {base[7:3], channel[1:0], 0}.
- R10: Channel 0 has the highest priority. `ien_out` is low while any channel is pending or in service. A channel in service blocks requests from channels of lower priority. With `ien_in` low, both `int_req` and `ien_out` are low.
- R11: A `reti` pulse ends service of the highest-priority channel in service. This releases waiting requests, or raises `ien_out` once nothing remains.
- R12: Bits 2:0 of a vector-base write have no effect on the vectors returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Write data |
| trig_in | input | 4 | Per-channel clock/trigger inputs |
| zc_out | output | 4 | Per-channel expiry pulses |
| ien_in | input | 1 | Daisy-chain enable from higher-priority devices |
| ien_out | output | 1 | Daisy-chain enable to lower-priority devices |
| int_req | output | 1 | Interrupt request |
| inta | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_out | output | 8 | Vector for the acknowledged channel |
| vec_valid | output | 1 | `vec_out` is valid this cycle |

## Verification
Every result has a fixed latency. A timer pulse is due 16·N or 256·N cycles after the constant write, or after the starting trigger edge. A counter pulse is due one cycle after its expiring edge. `int_req` follows one cycle after the pulse, and a vector follows one cycle after `inta`. The driver computes the exact cycle of each expected pulse and vector from these latencies and queues it. The monitor samples on the falling clock edge and pops an entry each time a pulse or vector appears. It compares both the channel or value and the cycle number. Any pulse that appears while nothing is queued is a failure, which covers the ignored-edge and halt cases.

// File: rtl/qct_pkg.sv
package qct_pkg;
    localparam int DW    = 8;
    localparam int NCH   = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int BASEW = DW - CHW - 1;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic irq_en;
        logic ext_count;
        logic pre_long;
        logic rise;
        logic await_trig;
        logic tc_next;
        logic halt;
        logic is_ctrl;
    } ctl_t;

    typedef enum logic [1:0] {CH_IDLE, CH_ARMED, CH_RUN} chst_t;

    // index of the lowest set bit (highest priority)
    function automatic logic [CHW-1:0] first_idx(input logic [NCH-1:0] v);
        logic [CHW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) r = CHW'(i);
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] lowest_bit(input logic [NCH-1:0] v);
        return v & (~v + NCH'(1));
    endfunction

    function automatic byte_t make_vec(input logic [BASEW-1:0] base,
                                       input logic [CHW-1:0] ch);
        return {base, ch, 1'b0};
    endfunction
endpackage

// File: rtl/qct_edge_det.sv
module qct_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_sel,
    output logic hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= din;
    end

    assign hit = rise_sel ? (din & ~prev) : (~din & prev);
endmodule

// File: rtl/qct_prescaler.sv
module qct_prescaler #(
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic long_sel,
    output logic tick
);
    localparam int PW = (PRE_LONG > 1) ? $clog2(PRE_LONG) : 1;

    logic [PW-1:0] pre;
    logic [PW-1:0] limit;

    assign limit = long_sel ? PW'(PRE_LONG - 1) : PW'(PRE_SHORT - 1);
    assign tick  = en && (pre == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre <= '0;
        else if (tick)   pre <= '0;
        else if (en)     pre <= pre + PW'(1);
    end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
    import qct_pkg::*;
#(
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wdata,
    input  logic  trig,
    output logic  zc,
    output logic  irq_en,
    output logic  wait_tc
);
    ctl_t  ctl;
    chst_t st;
    byte_t tconst;
    byte_t cnt;
    logic  hit, pre_tick, pre_clr, pre_en, step, load, start;

    qct_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .din      (trig),
        .rise_sel (ctl.rise),
        .hit      (hit)
    );

    assign load    = wr && wait_tc;
    assign start   = !wr && (st == CH_ARMED) && hit;
    assign pre_clr = load || start;
    assign pre_en  = !wr && (st == CH_RUN) && !ctl.ext_count;

    qct_prescaler #(
        .PRE_SHORT (PRE_SHORT),
        .PRE_LONG  (PRE_LONG)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (pre_clr),
        .en       (pre_en),
        .long_sel (ctl.pre_long),
        .tick     (pre_tick)
    );

    assign step   = !wr && (st == CH_RUN) && (ctl.ext_count ? hit : pre_tick);
    assign irq_en = ctl.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            st      <= CH_IDLE;
            tconst  <= '0;
            cnt     <= '0;
            wait_tc <= 1'b0;
            zc      <= 1'b0;
        end else begin
            zc <= 1'b0;
            if (load) begin
                tconst  <= wdata;
                cnt     <= wdata;
                wait_tc <= 1'b0;
                st      <= (!ctl.ext_count && ctl.await_trig) ? CH_ARMED : CH_RUN;
            end else if (wr && wdata[0]) begin
                ctl <= ctl_t'(wdata);
                if (wdata[2]) wait_tc <= 1'b1;
                if (wdata[1]) st      <= CH_IDLE;
            end else if (start) begin
                st <= CH_RUN;
            end else if (step) begin
                if (cnt == byte_t'(1)) begin
                    cnt <= tconst;
                    zc  <= 1'b1;
                end else begin
                    cnt <= cnt - byte_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/qct_irq_ctrl.sv
module qct_irq_ctrl
    import qct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   term,
    input  logic             ien_in,
    input  logic             inta,
    input  logic             reti,
    input  logic             base_we,
    input  logic [BASEW-1:0] base_d,
    output logic             int_req,
    output logic             ien_out,
    output byte_t            vec_out,
    output logic             vec_valid
);
    logic [NCH-1:0]   ip, isv, active, ack_mask, reti_mask;
    logic [CHW-1:0]   win;
    logic [BASEW-1:0] base;
    logic             ack;

    assign active    = ip | isv;
    assign win       = first_idx(active);
    assign int_req   = ien_in && (|active) && ip[win] && !isv[win];
    assign ien_out   = ien_in && !(|active);
    assign ack       = inta && int_req;
    assign ack_mask  = ack ? (NCH'(1) << win) : '0;
    assign reti_mask = reti ? lowest_bit(isv) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ip        <= '0;
            isv       <= '0;
            base      <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            ip        <= (ip & ~ack_mask) | term;
            isv       <= (isv & ~reti_mask) | ack_mask;
            vec_valid <= ack;
            if (ack)     vec_out <= make_vec(base, win);
            if (base_we) base    <= base_d;
        end
    end
endmodule

// File: rtl/quad_ctr_timer.sv
module quad_ctr_timer
    import qct_pkg::*;
#(
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_sel,
    input  logic [DW-1:0]  wr_data,
    input  logic [NCH-1:0] trig_in,
    output logic [NCH-1:0] zc_out,
    input  logic           ien_in,
    output logic           ien_out,
    output logic           int_req,
    input  logic           inta,
    input  logic           reti,
    output logic [DW-1:0]  vec_out,
    output logic           vec_valid
);
    logic [NCH-1:0] irq_en, wait_tc, term;
    logic           base_we;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        qct_channel #(
            .PRE_SHORT (PRE_SHORT),
            .PRE_LONG  (PRE_LONG)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_en && (wr_sel == CHW'(g))),
            .wdata   (wr_data),
            .trig    (trig_in[g]),
            .zc      (zc_out[g]),
            .irq_en  (irq_en[g]),
            .wait_tc (wait_tc[g])
        );
        assign term[g] = zc_out[g] & irq_en[g];
    end

    assign base_we = wr_en && (wr_sel == '0) && !wr_data[0] && !wait_tc[0];

    qct_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .term      (term),
        .ien_in    (ien_in),
        .inta      (inta),
        .reti      (reti),
        .base_we   (base_we),
        .base_d    (wr_data[DW-1:CHW+1]),
        .int_req   (int_req),
        .ien_out   (ien_out),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );
endmodule

// File: rtl/qct_checker.sv
module qct_checker
    import qct_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] zc_out,
    input logic           ien_in,
    input logic           ien_out,
    input logic           int_req,
    input logic           inta,
    input logic [DW-1:0]  vec_out,
    input logic           vec_valid
);
    for (genvar i = 0; i < NCH; i++) begin : g_zc
        // R2: expiry pulse is one cycle wide
        assert_zc_single_R2: assert property (@(posedge clk) disable iff (rst)
            zc_out[i] |=> !zc_out[i])
            else $error("zc_out[%0d] held longer than one cycle", i);
    end

    // R10: disabled chain blocks request and downstream enable
    assert_chain_off_R10: assert property (@(posedge clk) disable iff (rst)
        !ien_in |-> (!int_req && !ien_out))
        else $error("activity with ien_in low");

    // R10: a requesting block never passes the enable on
    assert_req_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        int_req |-> !ien_out)
        else $error("int_req and ien_out both high");

    // R9: an accepted acknowledge yields a vector next cycle
    assert_ack_vec_R9: assert property (@(posedge clk) disable iff (rst)
        (inta && int_req) |=> vec_valid)
        else $error("no vector after acknowledge");

    // R9: a vector only follows an accepted acknowledge
    assert_vec_cause_R9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta && int_req))
        else $error("vector without acknowledge");

    // R9: vector bit 0 is always clear
    assert_vec_lsb_R9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !vec_out[0])
        else $error("vector bit 0 set");
endmodule

bind quad_ctr_timer qct_checker u_qct_chk (
    .clk       (clk),
    .rst       (rst),
    .zc_out    (zc_out),
    .ien_in    (ien_in),
    .ien_out   (ien_out),
    .int_req   (int_req),
    .inta      (inta),
    .vec_out   (vec_out),
    .vec_valid (vec_valid)
);

// File: tb/quad_ctr_timer_bench.sv
module quad_ctr_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] trig_in = '0;
    logic [3:0] zc_out;
    logic       ien_in = 1'b1;
    logic       ien_out, int_req;
    logic       inta = 1'b0;
    logic       reti = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    string phase = "R1";

    typedef struct {
        int    val;
        int    cyc;
        string tag;
    } ev_t;

    ev_t zq[$];
    ev_t vq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_ctr_timer u_quad_ctr_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .trig_in(trig_in), .zc_out(zc_out), .ien_in(ien_in), .ien_out(ien_out),
        .int_req(int_req), .inta(inta), .reti(reti), .vec_out(vec_out),
        .vec_valid(vec_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push_zc(input int ch, input int at, input string tag);
        ev_t e;
        e.val = ch; e.cyc = at; e.tag = tag;
        zq.push_back(e);
    endtask

    // monitor: pops expectations as pulses and vectors appear
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                if (zc_out[i]) begin
                    if (zq.size() == 0) begin
                        chk(1'b0, {phase, " unexpected pulse"}, i, -1);
                    end else begin
                        ev_t e;
                        e = zq.pop_front();
                        chk(e.val == i, {e.tag, " pulse channel"}, i, e.val);
                        chk(e.cyc == cyc, {e.tag, " pulse cycle"}, cyc, e.cyc);
                    end
                end
            end
            if (vec_valid) begin
                if (vq.size() == 0) begin
                    chk(1'b0, {phase, " unexpected vector"}, vec_out, -1);
                end else begin
                    ev_t e;
                    e = vq.pop_front();
                    chk(e.val == int'(vec_out), {e.tag, " vector value"}, vec_out, e.val);
                    chk(e.cyc == cyc, {e.tag, " vector cycle"}, cyc, e.cyc);
                end
            end
        end
    end

    // returns the cycle stamp of the edge that samples the write
    task automatic cpu_wr(input int ch, input logic [7:0] d, output int stamp);
        @(negedge clk);
        stamp = cyc + 1;
        wr_en = 1'b1; wr_sel = 2'(ch); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int ch, input bit on_rise, input bit on_fall, input string tag);
        @(negedge clk);
        if (on_rise) push_zc(ch, cyc + 1, tag);
        trig_in[ch] = 1'b1;
        @(negedge clk);
        if (on_fall) push_zc(ch, cyc + 1, tag);
        trig_in[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack(input int exp_vec, input string tag);
        ev_t e;
        @(negedge clk);
        e.val = exp_vec; e.cyc = cyc + 1; e.tag = tag;
        vq.push_back(e);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL %s: watchdog actual hung expected finished", phase);
        finish_run();
    end

    initial begin
        int s, d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(zc_out == 4'b0, "R1 zc_out", zc_out, 0);
        chk(int_req == 1'b0, "R1 int_req", int_req, 0);
        chk(vec_valid == 1'b0, "R1 vec_valid", vec_valid, 0);
        chk(ien_out == ien_in, "R1 ien_out", ien_out, ien_in);
        rst = 1'b0;
        @(negedge clk);

        // R2: timer, prescale 16, constant 3, two periods
        phase = "R2";
        cpu_wr(1, 8'h05, d);
        cpu_wr(1, 8'd3, s);
        push_zc(1, s + 48, "R2");
        push_zc(1, s + 96, "R2");
        wait_until(s + 100);
        cpu_wr(1, 8'h03, d);

        // R3: prescale 256, constant 2
        phase = "R3";
        cpu_wr(2, 8'h25, d);
        cpu_wr(2, 8'd2, s);
        push_zc(2, s + 512, "R3");
        wait_until(s + 520);
        cpu_wr(2, 8'h03, d);

        // R7: halt before expiry, silent until a new constant
        phase = "R7";
        cpu_wr(2, 8'h05, d);
        cpu_wr(2, 8'd1, s);
        cpu_wr(2, 8'h03, d);
        wait_until(s + 60);
        cpu_wr(2, 8'h07, d);
        cpu_wr(2, 8'd1, s);
        push_zc(2, s + 16, "R7");
        wait_until(s + 20);
        cpu_wr(2, 8'h03, d);

        // R6: timer waits for a rising trigger edge
        phase = "R6";
        cpu_wr(1, 8'h1D, d);
        cpu_wr(1, 8'd1, s);
        wait_until(s + 40);
        @(negedge clk);
        s = cyc + 1;
        push_zc(1, s + 16, "R6");
        trig_in[1] = 1'b1;
        @(negedge clk);
        trig_in[1] = 1'b0;
        wait_until(s + 20);
        cpu_wr(1, 8'h03, d);

        // R5: counter mode, rising edges, constant 3
        phase = "R5";
        cpu_wr(3, 8'h55, d);
        cpu_wr(3, 8'd3, s);
        pulse(3, 0, 0, "R5");
        pulse(3, 0, 0, "R5");
        pulse(3, 1, 0, "R5");
        // R8: expiry without interrupt enable raises nothing
        chk(int_req == 1'b0, "R8 int_req without enable", int_req, 0);
        chk(ien_out == 1'b1, "R8 ien_out without enable", ien_out, 1);
        // R5: falling polarity, rising edges ignored
        cpu_wr(3, 8'h45, d);
        cpu_wr(3, 8'd2, s);
        pulse(3, 0, 0, "R5");
        pulse(3, 0, 1, "R5");
        cpu_wr(3, 8'h03, d);

        // R4: constant 0 counts 256 edges
        phase = "R4";
        cpu_wr(0, 8'h55, d);
        cpu_wr(0, 8'd0, s);
        for (int k = 1; k <= 256; k++) pulse(0, k == 256, 0, "R4");
        cpu_wr(0, 8'h03, d);

        // R12: vector base with junk in bits 2:0
        phase = "R12";
        cpu_wr(0, 8'hA6 | 8'h01 ^ 8'h01 | 8'h06, d);

        // R8: interrupt-enabled counters on channels 1 and 2
        phase = "R8";
        cpu_wr(1, 8'hD5, d);
        cpu_wr(1, 8'd1, d);
        cpu_wr(2, 8'hD5, d);
        cpu_wr(2, 8'd1, d);
        pulse(2, 1, 0, "R8");
        chk(int_req == 1'b1, "R8 int_req after expiry", int_req, 1);
        chk(ien_out == 1'b0, "R10 ien_out while pending", ien_out, 0);

        // R10: chain disabled from above
        phase = "R10";
        @(negedge clk);
        ien_in = 1'b0;
        @(negedge clk);
        chk(int_req == 1'b0, "R10 int_req with ien_in low", int_req, 0);
        chk(ien_out == 1'b0, "R10 ien_out with ien_in low", ien_out, 0);
        ien_in = 1'b1;
        pulse(1, 1, 0, "R10");

        // R9/R10: channel 1 outranks channel 2
        phase = "R9";
        ack(8'hA2, "R9");
        chk(int_req == 1'b0, "R10 lower channel blocked in service", int_req, 0);
        chk(ien_out == 1'b0, "R10 ien_out in service", ien_out, 0);

        // R11: return releases channel 2
        phase = "R11";
        do_reti();
        chk(int_req == 1'b1, "R11 request after return", int_req, 1);
        ack(8'hA4, "R12");
        chk(int_req == 1'b0, "R11 no request in service", int_req, 0);
        do_reti();
        chk(ien_out == 1'b1, "R11 ien_out released", ien_out, 1);
        chk(int_req == 1'b0, "R11 idle request", int_req, 0);
        cpu_wr(1, 8'h03, d);
        cpu_wr(2, 8'h03, d);

        repeat (20) @(negedge clk);
        chk(zq.size() == 0, "R2 pulses still outstanding", zq.size(), 0);
        chk(vq.size() == 0, "R9 vectors still outstanding", vq.size(), 0);
        finish_run();
    end
endmodule